// File: doc/BRIEF.md
# Byte and Bit Manipulation Unit

A 64-bit integer execution sub-unit for bit-level operations on general-purpose operands. Each issued operation carries a 3-bit opcode and two 64-bit sources. The unit can compare operands byte by byte, count ones in byte, word or doubleword fields, gather eight arbitrary bits of one operand under control of eight index bytes, and fold the low bits of bytes into word or doubleword parity.

All operations go through one shared two-stage pipeline. The first stage computes per-byte partial results in eight identical lanes: a ones count, an equality flag, the byte's low bit and one gathered bit. The second stage merges the lanes according to the opcode into a registered result. A new operation may be issued on every clock.

Top module: `bbm_unit`

## Requirements
- R1: An operation with `valid_i` high sampled at clock edge n appears on `result_o` with `valid_o` high right after edge n+1. Operations may be issued on consecutive cycles with no gap.
- R2: During and after reset `valid_o` is low. Whenever `valid_o` is low, `result_o` is all zero.
- R3: Opcode 0 (compare bytes): each result byte is 0xFF when the bytes of `a_i` and `b_i` at that position are equal, and 0x00 otherwise.
- R4: Opcode 1 (count per byte): each result byte holds the number of ones in the same byte of `a_i`, from 0 to 8.
- R5: Opcode 2 (count per word): each 32-bit half of the result holds the number of ones in that half of `a_i`, from 0 to 32.
- R6: Opcode 3 (count per doubleword): the result holds the number of ones in all of `a_i`, from 0 to 64.
- R7: Opcode 4 (bit gather): bits are numbered MSB-first, so bit 0 is bit 63 of `b_i`. For k from 0 to 7, result bit k takes bit `a_i[8k+7:8k]` of `b_i` in that numbering.
- R8: Opcode 4: an index byte of 64 or more yields a zero in its result bit. Result bits 63:8 are always zero.
- R9: Opcode 5 (word parity): result bit 0 is the XOR of bits 0, 8, 16 and 24 of `a_i`. Result bit 32 is the XOR of bits 32, 40, 48 and 56. All other result bits are zero.
- R10: Opcode 6 (doubleword parity): result bit 0 is the XOR of the low bit of all eight bytes of `a_i`. All other result bits are zero.
- R11: Opcode 7 is reserved. It completes with `valid_o` high and an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation issue strobe |
| op_i | input | 3 | Opcode select |
| a_i | input | 64 | First source: operand, or index bytes for the gather |
| b_i | input | 64 | Second source: compare operand, or data for the gather |
| valid_o | output | 1 | Result strobe, two cycles after issue |
| result_o | output | 64 | Operation result |

## Verification
The bench builds the unit at its default XLEN of 64, which gives eight byte lanes and two words. That is the width at which every count extreme (8, 32 and 64) and the index boundary between 63 and 64 can be reached. Directed operands put all-ones, all-zero and alternating patterns in every lane. Gather indices land on both edges of the valid range and beyond it. Opcodes change on every cycle, with and without bubbles, so that a stage holding the wrong opcode or stale lane data shows up against the reference queue.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
  typedef enum logic [2:0] {
    OP_CMPB  = 3'd0,
    OP_CNT_B = 3'd1,
    OP_CNT_W = 3'd2,
    OP_CNT_D = 3'd3,
    OP_PERM  = 3'd4,
    OP_PAR_W = 3'd5,
    OP_PAR_D = 3'd6,
    OP_RSVD  = 3'd7
  } bbm_op_e;
endpackage

// File: rtl/bbm_lane.sv
module bbm_lane #(
  parameter int XLEN = 64
) (
  input  logic [7:0]      a_byte_i,
  input  logic [7:0]      b_byte_i,
  input  logic [XLEN-1:0] data_i,
  output logic [3:0]      cnt_o,
  output logic            eq_o,
  output logic            lsb_o,
  output logic            perm_o
);
  localparam int IW = $clog2(XLEN);

  logic [XLEN-1:0] data_rev;

  always_comb begin
    for (int j = 0; j < XLEN; j++) data_rev[j] = data_i[XLEN-1-j];
  end

  always_comb begin
    cnt_o = '0;
    for (int j = 0; j < 8; j++) cnt_o = cnt_o + 4'(a_byte_i[j]);
  end

  assign eq_o  = (a_byte_i == b_byte_i);
  assign lsb_o = a_byte_i[0];
  // MSB-first numbering: index 0 selects the top bit of the data
  assign perm_o = (int'(a_byte_i) < XLEN) ? data_rev[a_byte_i[IW-1:0]] : 1'b0;
endmodule

// File: rtl/bbm_merge.sv
module bbm_merge
  import bbm_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                  vld_i,
  input  bbm_op_e               op_i,
  input  logic [XLEN/8-1:0][3:0] cnt_i,
  input  logic [XLEN/8-1:0]     eq_i,
  input  logic [XLEN/8-1:0]     lsb_i,
  input  logic [XLEN/8-1:0]     perm_i,
  output logic [XLEN-1:0]       res_o
);
  localparam int NB  = XLEN / 8;
  localparam int BPW = 4;
  localparam int NW  = NB / BPW;

  logic [NW-1:0][7:0] wsum;
  logic [7:0]         dsum;
  logic [NW-1:0]      wpar;

  always_comb begin
    dsum = '0;
    for (int w = 0; w < NW; w++) begin
      wsum[w] = '0;
      wpar[w] = 1'b0;
      for (int b = 0; b < BPW; b++) begin
        wsum[w] = wsum[w] + 8'(cnt_i[w*BPW+b]);
        wpar[w] = wpar[w] ^ lsb_i[w*BPW+b];
      end
      dsum = dsum + wsum[w];
    end
  end

  always_comb begin
    res_o = '0;
    if (vld_i) begin
      unique case (op_i)
        OP_CMPB:  for (int b = 0; b < NB; b++) res_o[8*b +: 8] = {8{eq_i[b]}};
        OP_CNT_B: for (int b = 0; b < NB; b++) res_o[8*b +: 8] = {4'b0, cnt_i[b]};
        OP_CNT_W: for (int w = 0; w < NW; w++) res_o[32*w +: 32] = {24'b0, wsum[w]};
        OP_CNT_D: res_o[7:0] = dsum;
        OP_PERM:  res_o[NB-1:0] = perm_i;
        OP_PAR_W: for (int w = 0; w < NW; w++) res_o[32*w] = wpar[w];
        OP_PAR_D: res_o[0] = ^lsb_i;
        default:  res_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/bbm_unit.sv
module bbm_unit
  import bbm_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            valid_o,
  output logic [XLEN-1:0] result_o
);
  localparam int NB = XLEN / 8;

  logic [NB-1:0][3:0] cnt_d, cnt_q;
  logic [NB-1:0]      eq_d, eq_q, lsb_d, lsb_q, perm_d, perm_q;
  bbm_op_e            op_q;
  logic               vld_q;
  logic [XLEN-1:0]    res_d;

  for (genvar k = 0; k < NB; k++) begin : g_lane
    bbm_lane #(.XLEN(XLEN)) u_lane (
      .a_byte_i (a_i[8*k +: 8]),
      .b_byte_i (b_i[8*k +: 8]),
      .data_i   (b_i),
      .cnt_o    (cnt_d[k]),
      .eq_o     (eq_d[k]),
      .lsb_o    (lsb_d[k]),
      .perm_o   (perm_d[k])
    );
  end

  // stage 1: lane partials
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      op_q   <= OP_RSVD;
      cnt_q  <= '0;
      eq_q   <= '0;
      lsb_q  <= '0;
      perm_q <= '0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) begin
        op_q   <= bbm_op_e'(op_i);
        cnt_q  <= cnt_d;
        eq_q   <= eq_d;
        lsb_q  <= lsb_d;
        perm_q <= perm_d;
      end
    end
  end

  bbm_merge #(.XLEN(XLEN)) u_merge (
    .vld_i  (vld_q),
    .op_i   (op_q),
    .cnt_i  (cnt_q),
    .eq_i   (eq_q),
    .lsb_i  (lsb_q),
    .perm_i (perm_q),
    .res_o  (res_d)
  );

  // stage 2: merged result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o  <= vld_q;
      result_o <= res_d;
    end
  end
endmodule

// File: rtl/bbm_unit_chk.sv
module bbm_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [2:0]      op_i,
  input logic [XLEN-1:0] a_i,
  input logic [XLEN-1:0] b_i,
  input logic            valid_o,
  input logic [XLEN-1:0] result_o
);
  localparam int NB = XLEN / 8;

  logic [1:0] warm_q;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end
  assign warm = (warm_q == 2'd2);

  function automatic logic bytes_mask(logic [XLEN-1:0] r);
    logic ok = 1'b1;
    for (int b = 0; b < NB; b++)
      if (r[8*b +: 8] != 8'h00 && r[8*b +: 8] != 8'hff) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic bytes_le8(logic [XLEN-1:0] r);
    logic ok = 1'b1;
    for (int b = 0; b < NB; b++)
      if (r[8*b +: 8] > 8'd8) ok = 1'b0;
    return ok;
  endfunction

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni || !warm)
    valid_o == $past(valid_i, 2)); // R1

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> result_o == '0); // R2

  AST_CMPB_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni || !warm)
    (valid_o && $past(op_i, 2) == 3'd0) |-> bytes_mask(result_o)); // R3

  AST_CNTB_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni || !warm)
    (valid_o && $past(op_i, 2) == 3'd1) |-> bytes_le8(result_o)); // R4

  AST_PERM_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni || !warm)
    (valid_o && $past(op_i, 2) == 3'd4) |-> result_o[XLEN-1:8] == '0); // R8

  AST_PARW_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni || !warm)
    (valid_o && $past(op_i, 2) == 3'd5) |-> $countones(result_o) == $countones({result_o[32], result_o[0]})); // R9

  AST_PARD_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni || !warm)
    (valid_o && $past(op_i, 2) == 3'd6) |-> result_o[XLEN-1:1] == '0); // R10

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni || !warm)
    (valid_o && $past(op_i, 2) == 3'd7) |-> result_o == '0); // R11
endmodule

bind bbm_unit bbm_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/bbm_unit_test.sv
`timescale 1ns/1ps
module bbm_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic        valid_o;
  logic [63:0] result_o;

  int n_chk = 0;
  int n_fail = 0;

  bit          exp_v[$];
  logic [63:0] exp_r[$];
  string       exp_t[$];

  bbm_unit uut (.*);

  always #4 clk_i = ~clk_i;

  function automatic logic [63:0] ref_fn(logic [2:0] op, logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    int c, idx;
    logic p;
    case (op)
      3'd0: for (int i = 0; i < 8; i++) if (a[8*i +: 8] == b[8*i +: 8]) r[8*i +: 8] = 8'hff;
      3'd1: for (int i = 0; i < 8; i++) begin
              c = 0;
              for (int j = 0; j < 8; j++) c += a[8*i+j];
              r[8*i +: 8] = 8'(c);
            end
      3'd2: for (int w = 0; w < 2; w++) begin
              c = 0;
              for (int j = 0; j < 32; j++) c += a[32*w+j];
              r[32*w +: 32] = 32'(c);
            end
      3'd3: begin
              c = 0;
              for (int j = 0; j < 64; j++) c += a[j];
              r = 64'(c);
            end
      3'd4: for (int i = 0; i < 8; i++) begin
              idx = int'(a[63-8*i -: 8]);
              r[7-i] = (idx < 64) ? b[63-idx] : 1'b0;
            end
      3'd5: for (int w = 0; w < 2; w++) begin
              p = 1'b0;
              for (int i = 0; i < 4; i++) p ^= a[32*w+8*i];
              r[32*w] = p;
            end
      3'd6: begin
              p = 1'b0;
              for (int i = 0; i < 8; i++) p ^= a[8*i];
              r[0] = p;
            end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(bit v, logic [2:0] op);
    if (!v) return "R2";
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R9";
      3'd6: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(bit ok, string tg, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tg, act, exp, $time);
    end
  endtask

  task automatic step(bit v, logic [2:0] op, logic [63:0] a, logic [63:0] b, string tg);
    bit ev;
    logic [63:0] er;
    string et;
    @(negedge clk_i);
    ev = exp_v.pop_front();
    er = exp_r.pop_front();
    et = exp_t.pop_front();
    chk(valid_o === ev, "R1", 64'(valid_o), 64'(ev));
    chk(result_o === er, et, result_o, er);
    valid_i = v; op_i = op; a_i = a; b_i = b;
    exp_v.push_back(v);
    exp_r.push_back(v ? ref_fn(op, a, b) : 64'h0);
    exp_t.push_back(tg != "" ? tg : tag_of(v, op));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(valid_o === 1'b0, "R2", 64'(valid_o), 64'h0);
    chk(result_o === 64'h0, "R2", result_o, 64'h0);
    rst_ni = 1'b1;
    repeat (2) begin exp_v.push_back(1'b0); exp_r.push_back('0); exp_t.push_back("R2"); end

    // R3 compare bytes
    step(1, 3'd0, 64'hdeadbeef_00112233, 64'hdeadbeef_00000000, "");
    step(1, 3'd0, 64'h0, 64'h0, "");
    step(1, 3'd0, 64'h0123456789abcdef, 64'hfedcba9876543210, "");
    // R4 R5 R6 counts, extremes
    step(1, 3'd1, 64'h00112233_44556677, 64'h0, "");
    step(1, 3'd1, 64'hffffffff_ffffffff, 64'h0, "");
    step(1, 3'd2, 64'hffffffff_00000001, 64'h0, "");
    step(1, 3'd2, 64'haaaaaaaa_55555555, 64'h0, "");
    step(1, 3'd3, 64'hffffffff_ffffffff, 64'h0, "");
    step(1, 3'd3, 64'h0, 64'h0, "");
    step(0, 3'd3, 64'hffff, 64'h0, "");
    step(1, 3'd3, 64'h80000000_00000001, 64'h0, "");
    // R7 gather, MSB-first
    step(1, 3'd4, 64'h20212324_30313233, 64'h00112233_44556677, "");
    step(1, 3'd4, 64'h08090a0b_5c5d5e5f, 64'hffeeddcc_bbaa9988, "");
    step(1, 3'd4, 64'h00003f01_3e020304, 64'h80000000_00000001, "");
    // R8 out of range indices
    step(1, 3'd4, 64'h40ff3f41_80007f3f, 64'hffffffff_ffffffff, "R8");
    step(1, 3'd4, 64'h40404040_40404040, 64'hffffffff_ffffffff, "R8");
    // R9 R10 parity
    step(1, 3'd5, 64'h10111313_00000000, 64'h0, "");
    step(1, 3'd5, 64'h01000000_00000001, 64'h0, "");
    step(1, 3'd6, 64'h00415101_00617100, 64'h0, "");
    step(1, 3'd6, 64'hfefefefe_fefefefe, 64'h0, "");
    // R11 reserved
    step(1, 3'd7, 64'hffffffff_ffffffff, 64'hffffffff_ffffffff, "");
    step(0, 3'd0, 64'h1, 64'h1, "");
    step(1, 3'd7, 64'h0, 64'h0, "");
    // R1 back-to-back mixed traffic with bubbles
    for (int n = 0; n < 400; n++) begin
      logic [63:0] a, b;
      logic [2:0]  op;
      a  = {$urandom, $urandom};
      b  = {$urandom, $urandom};
      op = 3'($urandom_range(0, 7));
      if (op == 3'd4 && n[0]) a = a & 64'h7f7f7f7f_7f7f7f7f;
      if (op == 3'd0 && n[1]) b = a ^ (64'hff << (8 * (n % 8)));
      step(($urandom_range(0, 4) != 0), op, a, b, "");
    end
    repeat (3) step(0, 3'd0, 64'h0, 64'h0, "");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule